// File: doc/BRIEF.md
# Gated-Read RAM with Bypass Selector

This block is a single-port synchronous RAM. Its registered read data competes with a bypass input at a registered output selector. Every control and data input is captured in a register before use. The select travels through two stages, an early stage and a late stage. The late stage steers the output selector. The early stage tells the RAM one cycle ahead whether its read result will be wanted.

The RAM array is enabled only when a registered write is pending or the early select stage is high. In every other cycle the array does no access and its read register keeps its old value. Reads whose data the selector would throw away are never performed. The output sequence is the same as that of a RAM that is enabled in every cycle.

A free-running counter reports how many clock edges saw the array enabled, so the gating ratio can be read directly. The default geometry is 8-bit data and a 12-bit address. The array is an inferred memory.

Top module: `ram_bypass_gate`

## Requirements
- R1: After a synchronous active-low reset, `result_o` and `act_cnt_o` are zero, and all pipeline registers hold zero.
- R2: Write enable, select, address and write data presented before rising edge n are captured at edge n. Their effect on `result_o` appears after edge n+2. The bypass value used at that point is the one presented before edge n+2.
- R3: A registered write enable stores the registered write data at the registered address. A later selected read of that address returns it.
- R4: `result_o` takes the RAM read data when the late select stage is high, and takes `byp_i` when it is low.
- R5: A read in the same cycle as a write to the same address returns the newly written data (write-first).
- R6: The array is enabled exactly when the registered write enable or the early select stage is high. When it is disabled, nothing is written and the read register holds its value. `act_cnt_o` rises by one for each edge with the array enabled. Inputs presented before edge n are counted at edge n+1.
- R7: For any stimulus after reset, `result_o` matches an ungated reference whose array is enabled in every cycle.
- R8: With the write enable random at 50% and a random select, the enabled fraction reported by `act_cnt_o` lies between 68% and 82%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| sel_i | input | 1 | 1 selects RAM read data, 0 selects the bypass |
| addr_i | input | ADDR_W (12) | RAM address |
| wdata_i | input | DATA_W (8) | Write data |
| byp_i | input | DATA_W (8) | Bypass data |
| result_o | output | DATA_W (8) | Registered selector output |
| act_cnt_o | output | CNT_W (32) | Count of edges with the array enabled |

## Verification
A write followed two cycles later by a selected read shows the three-edge latency and the stored value. A bypass-only stream shows that the late select stage picks the bypass sampled at the final edge. A write and a select issued together at one address separate write-first behaviour from returning the old contents. Bursts of writes only, selects only, both together and idle cycles give an exact expected change in the activity counter. A long random run with addresses confined to preloaded locations compares every output against an ungated reference model and measures the enabled fraction.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_CNT_W  = 32;

    // Array enable rule: any pending write, or a read that will be consumed.
    function automatic logic array_wanted(input logic wr_pend, input logic rd_used);
        return wr_pend | rd_used;
    endfunction
endpackage

// File: rtl/rbg_in_stage.sv
module rbg_in_stage #(
    parameter int DATA_W = rbg_pkg::DEF_DATA_W,
    parameter int ADDR_W = rbg_pkg::DEF_ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              we_o,
    output logic              pre_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    typedef struct packed {
        logic              we;
        logic              pre;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.we   = wr_en_i;
        cap_d.pre  = sel_i;
        cap_d.addr = addr_i;
        cap_d.wd   = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign we_o    = cap_q.we;
    assign pre_o   = cap_q.pre;
    assign addr_o  = cap_q.addr;
    assign wdata_o = cap_q.wd;

    // R2
    cap_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |=> pre_o);
endmodule

// File: rtl/rbg_array.sv
module rbg_array #(
    parameter int DATA_W = rbg_pkg::DEF_DATA_W,
    parameter int ADDR_W = rbg_pkg::DEF_ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } rd_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (en_i) begin
            rd_d.rd = we_i ? wdata_i : mem_q[addr_i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (en_i && we_i) mem_q[addr_i] <= wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rdata_o = rd_q.rd;

    // R6
    rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(rdata_o));
    // R5
    wr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/rbg_out_stage.sv
module rbg_out_stage #(
    parameter int DATA_W = rbg_pkg::DEF_DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pre_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] byp_i,
    output logic [DATA_W-1:0] result_o
);
    typedef struct packed {
        logic              sel;
        logic [DATA_W-1:0] res;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.sel = pre_i;
        out_d.res = out_q.sel ? rdata_i : byp_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign result_o = out_q.res;

    // R2
    sel_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_i |=> out_q.sel);
    // R4
    mux_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_q.sel |=> (result_o == $past(rdata_i)));
    // R4
    mux_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_q.sel |=> (result_o == $past(byp_i)));
endmodule

// File: rtl/rbg_act_cnt.sv
module rbg_act_cnt #(
    parameter int CNT_W = rbg_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (en_i) c_d.cnt = c_q.cnt + ONE;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign cnt_o = c_q.cnt;

    // R6
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (cnt_o == $past(cnt_o) + ONE));
    // R6
    cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/ram_bypass_gate.sv
module ram_bypass_gate #(
    parameter int DATA_W = rbg_pkg::DEF_DATA_W,
    parameter int ADDR_W = rbg_pkg::DEF_ADDR_W,
    parameter int CNT_W  = rbg_pkg::DEF_CNT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] byp_i,
    output logic [DATA_W-1:0] result_o,
    output logic [CNT_W-1:0]  act_cnt_o
);
    logic              we_q, pre_q, arr_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q, rdata;

    rbg_in_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_in (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .sel_i(sel_i),
        .addr_i(addr_i), .wdata_i(wdata_i),
        .we_o(we_q), .pre_o(pre_q), .addr_o(addr_q), .wdata_o(wd_q));

    assign arr_en = rbg_pkg::array_wanted(we_q, pre_q);

    rbg_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(arr_en), .we_i(we_q),
        .addr_i(addr_q), .wdata_i(wd_q), .rdata_o(rdata));

    rbg_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .pre_i(pre_q), .rdata_i(rdata),
        .byp_i(byp_i), .result_o(result_o));

    rbg_act_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(arr_en), .cnt_o(act_cnt_o));

    // R1
    rst_zero_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (result_o == '0 && act_cnt_o == '0));
endmodule

// File: tb/sim_ram_bypass_gate.sv
module sim_ram_bypass_gate;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0, sel_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [7:0]  wdata_i = '0, byp_i = '0;
    logic [7:0]  result_o;
    logic [31:0] act_cnt_o;

    int checks = 0, failures = 0, cycles = 0;

    always #10 clk = ~clk;

    ram_bypass_gate u0 (
        .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .sel_i(sel_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .byp_i(byp_i),
        .result_o(result_o), .act_cnt_o(act_cnt_o));

    // Ungated reference (R7): array enabled in every cycle, write-first.
    logic        r_we, r_pre, r_sel;
    logic [11:0] r_addr;
    logic [7:0]  r_wd, r_rd, r_res;
    logic [7:0]  r_mem [4096];
    always @(posedge clk) begin
        if (!rst_ni) begin
            r_we <= 0; r_pre <= 0; r_sel <= 0; r_addr <= 0;
            r_wd <= 0; r_rd <= 0; r_res <= 0;
        end else begin
            r_we <= wr_en_i; r_pre <= sel_i; r_addr <= addr_i; r_wd <= wdata_i;
            if (r_we) begin r_mem[r_addr] <= r_wd; r_rd <= r_wd; end
            else r_rd <= r_mem[r_addr];
            r_sel <= r_pre;
            r_res <= r_sel ? r_rd : byp_i;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic we, input logic sel, input logic [11:0] a,
                        input logic [7:0] d, input logic [7:0] b);
        @(negedge clk);
        wr_en_i = we; sel_i = sel; addr_i = a; wdata_i = d; byp_i = b;
    endtask

    task automatic idle(input int n, input logic [7:0] b);
        for (int i = 0; i < n; i++) tick(0, 0, 12'h0, 8'h0, b);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 result after reset", result_o, 0);
        chk("R1 counter after reset", act_cnt_o, 0);
    endtask

    task automatic t_write_read;
        tick(1, 0, 12'h005, 8'hA5, 8'h33);
        idle(1, 8'h33);
        tick(0, 1, 12'h005, 8'h00, 8'h33);   // select at tick k
        tick(0, 0, 12'h000, 8'h00, 8'h33);
        tick(0, 0, 12'h000, 8'h00, 8'h44);   // tick k+2
        chk("R2 result still bypass before third edge", result_o, 8'h33);
        tick(0, 0, 12'h000, 8'h00, 8'h55);   // tick k+3
        chk("R3 stored value read back", result_o, 8'hA5);
    endtask

    task automatic t_bypass;
        tick(0, 0, 12'h005, 8'h00, 8'h01);
        tick(0, 0, 12'h005, 8'h00, 8'h02);
        tick(0, 0, 12'h005, 8'h00, 8'h5C);
        tick(0, 0, 12'h005, 8'h00, 8'h6D);
        chk("R4 bypass taken when select low", result_o, 8'h5C);
        tick(0, 0, 12'h005, 8'h00, 8'h7E);
        chk("R4 bypass follows input", result_o, 8'h6D);
    endtask

    task automatic t_write_first;
        tick(1, 0, 12'h009, 8'h11, 8'h00);
        idle(2, 8'h00);
        tick(1, 1, 12'h009, 8'h3C, 8'h00);
        idle(3, 8'h00);
        chk("R5 write-first returns new data", result_o, 8'h3C);
        tick(0, 1, 12'h009, 8'h00, 8'h00);
        idle(3, 8'h00);
        chk("R3 new data persisted", result_o, 8'h3C);
    endtask

    task automatic t_count;
        logic [31:0] c0;
        idle(3, 8'h00);
        c0 = act_cnt_o;
        for (int i = 0; i < 4; i++) tick(1, 0, 12'(20 + i), 8'(i), 8'h00);
        for (int i = 0; i < 3; i++) tick(0, 1, 12'(20 + i), 8'h00, 8'h00);
        idle(5, 8'h00);
        chk("R6 idle cycles not counted", act_cnt_o, c0 + 7);
        tick(1, 1, 12'h030, 8'h99, 8'h00);
        tick(0, 0, 12'h000, 8'h00, 8'h00);
        chk("R6 count lags by one edge", act_cnt_o, c0 + 7);
        tick(0, 0, 12'h000, 8'h00, 8'h00);
        chk("R6 write plus select counted once", act_cnt_o, c0 + 8);
    endtask

    task automatic t_random;
        logic [31:0] c0;
        int bad = 0;
        for (int i = 0; i < 16; i++) tick(1, 0, 12'(i), 8'($urandom), 8'h00);
        idle(3, 8'h00);
        c0 = act_cnt_o;
        for (int i = 0; i < 2000; i++) begin
            tick(1'($urandom), 1'($urandom), 12'($urandom_range(0, 15)),
                 8'($urandom), 8'($urandom));
            checks++;
            if (result_o !== r_res) begin
                failures++; bad++;
                if (bad < 5)
                    $display("FAIL R7 cycle %0d actual=%0h expected=%0h", i, result_o, r_res);
            end
        end
        checks++;
        if ((act_cnt_o - c0) < 1360 || (act_cnt_o - c0) > 1640) begin
            failures++;
            $display("FAIL R8 enabled edges actual=%0d expected=1360..1640", act_cnt_o - c0);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_write_read();
        t_bypass();
        t_write_first();
        t_count();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule